// File: doc/BRIEF.md
# Phase-Shifted Multi-Mode PWM Channel

This block is one pulse-width channel that hangs off a shared master time base. The master counter counts up from zero to a programmable period and then wraps. On each master wrap, the channel's own 13-bit counter is reloaded with a phase offset, so several channels built from this block can be staggered against one another. As an alternative, the channel can ignore the master and run on a period of its own, which is held in its phase register.

The channel compares its counter against a 16-bit duty word. Only the upper 13 bits of that word take part in the comparison. The duty word comes either from the channel's own duty register or from a master duty register shared with other channels. Duty, phase and master period writes pass through shadow registers and take effect at defined boundaries. The duty and the master period also have an immediate-update option.

The pulse drives a high/low pin pair in one of three formats: complementary, independent or push-pull. In push-pull format the pulse moves to the other pin on each period.

Top module: `pwm_phase_gen`

## Requirements
- R1: While enabled, the master counter counts 0,1,…,P and then returns to 0, where P is the active master period. `mst_roll_o` is high exactly in the cycle in which the master counter equals P.
- R2: A master period write goes to a shadow register. The shadow value becomes active at the next master wrap, or at once while the block is disabled. When `imm_per_i` is 1, the written value becomes active on the clock edge of the write.
- R3: When not in independent mode, the channel counter loads min(active phase, active master period) on every master wrap. On any other cycle it returns to 0 after it equals the master period, and otherwise it increments.
- R4: A phase write goes to a shadow register. The shadow moves to the active phase on the channel's own rollover, or at once while the block is disabled.
- R5: When `itb_i`=1, the channel counter counts 0 up to the active phase value, then returns to 0. It does not depend on master wraps.
- R6: The raw pulse is 1 exactly when the module is enabled and the channel counter is ≤ bits [15:3] of the effective duty. Bits [2:0] have no effect.
- R7: When `mdc_sel_i`=1, the duty source is the master duty register. When it is 0, the source is the channel duty register.
- R8: When `imm_duty_i`=0, the effective duty is a copy of the selected source that is taken at each channel rollover, or continuously while disabled. When `imm_duty_i`=1, the selected source is used directly.
- R9: `mode_i`=2'b00 (complementary): high pin = raw, low pin = NOT raw.
- R10: `mode_i`=2'b01 (independent): both pins carry the raw pulse.
- R11: `mode_i`=2'b10 (push-pull): a selector flips on every channel rollover and is cleared to 0 while the block is disabled. When the selector is 0 the high pin carries raw; when it is 1 the low pin carries raw. The other pin is 0.
- R12: `mode_i`=2'b11 (reserved): both pins are 0.
- R13: While `en_i`=0, both counters are held at 0 and both pins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Module enable |
| wr_mper_i | input | 1 | Master period write strobe |
| mper_i | input | 13 | Master period write data |
| imm_per_i | input | 1 | Apply period writes immediately |
| wr_mdc_i | input | 1 | Master duty write strobe |
| mdc_i | input | 16 | Master duty write data |
| wr_pdc_i | input | 1 | Channel duty write strobe |
| pdc_i | input | 16 | Channel duty write data |
| wr_ph_i | input | 1 | Phase/own-period write strobe |
| ph_i | input | 13 | Phase/own-period write data |
| mdc_sel_i | input | 1 | Select master duty register |
| itb_i | input | 1 | Independent time-base mode |
| imm_duty_i | input | 1 | Apply duty changes immediately |
| mode_i | input | 2 | Output format |
| pwm_hi_o | output | 1 | High pin |
| pwm_lo_o | output | 1 | Low pin |
| ch_cnt_o | output | 13 | Channel counter |
| mst_roll_o | output | 1 | Master wrap pulse |

## Verification
The bench builds the block with its default widths: a 13-bit counter and a 16-bit duty word. It keeps master periods and own periods at 20 counts or less, so each stimulus episode covers many wraps, shadow transfers and push-pull flips. The phase values it draws can exceed the period, which reaches the clamp. The duty values it draws can exceed the period, which reaches a pulse that never turns off, and they carry random values in the three ignored low bits.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  typedef enum logic [1:0] {
    OM_COMPL    = 2'b00,
    OM_INDEP    = 2'b01,
    OM_PUSHPULL = 2'b10,
    OM_RSVD     = 2'b11
  } out_mode_e;
endpackage

// File: rtl/pwm_master_tb.sv
module pwm_master_tb #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_per_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             imm_per_i,
  output logic [CNT_W-1:0] per_act_o,
  output logic             roll_o
);
  logic [CNT_W-1:0] cnt_q, per_sh_q, per_act_q;

  assign roll_o    = en_i && (cnt_q == per_act_q);
  assign per_act_o = per_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      per_sh_q  <= '0;
      per_act_q <= '0;
    end else begin
      if (wr_per_i) per_sh_q <= per_i;
      if (wr_per_i && imm_per_i)   per_act_q <= per_i;
      else if (!en_i || roll_o)    per_act_q <= per_sh_q;
      cnt_q <= (!en_i || roll_o) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_chan_cnt.sv
module pwm_chan_cnt #(
  parameter int CNT_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             itb_i,
  input  logic             mroll_i,
  input  logic [CNT_W-1:0] mper_i,
  input  logic             wr_ph_i,
  input  logic [CNT_W-1:0] ph_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             roll_o
);
  logic [CNT_W-1:0] cnt_q, ph_sh_q, ph_act_q, ph_clamp, wrap_at;

  assign wrap_at  = itb_i ? ph_act_q : mper_i;
  assign roll_o   = en_i && (cnt_q == wrap_at);
  assign ph_clamp = (ph_act_q > mper_i) ? mper_i : ph_act_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      ph_sh_q  <= '0;
      ph_act_q <= '0;
    end else begin
      if (wr_ph_i) ph_sh_q <= ph_i;
      if (!en_i || roll_o) ph_act_q <= ph_sh_q;
      if (!en_i)                cnt_q <= '0;
      else if (!itb_i && mroll_i) cnt_q <= ph_clamp;  // phase reload wins
      else if (roll_o)          cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_out_fmt.sv
module pwm_out_fmt
  import pwm_phase_pkg::*;
#(
  parameter int CNT_W  = 13,
  parameter int DUTY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              roll_i,
  input  logic [1:0]        mode_i,
  input  logic              mdc_sel_i,
  input  logic              imm_duty_i,
  input  logic              wr_pdc_i,
  input  logic [DUTY_W-1:0] pdc_i,
  input  logic              wr_mdc_i,
  input  logic [DUTY_W-1:0] mdc_i,
  output logic              hi_o,
  output logic              lo_o
);
  localparam int FRAC_W = DUTY_W - CNT_W;

  logic [DUTY_W-1:0] pdc_q, mdc_q, duty_act_q, duty_src, duty_eff;
  logic              pp_q, raw, duty_unused;
  out_mode_e         mode;

  assign duty_src    = mdc_sel_i ? mdc_q : pdc_q;
  assign duty_eff    = imm_duty_i ? duty_src : duty_act_q;
  assign duty_unused = ^duty_eff[FRAC_W-1:0];
  assign raw         = en_i && (cnt_i <= duty_eff[DUTY_W-1:FRAC_W]);
  assign mode        = out_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdc_q      <= '0;
      mdc_q      <= '0;
      duty_act_q <= '0;
      pp_q       <= 1'b0;
    end else begin
      if (wr_pdc_i) pdc_q <= pdc_i;
      if (wr_mdc_i) mdc_q <= mdc_i;
      if (!en_i || roll_i) duty_act_q <= duty_src;
      if (!en_i)       pp_q <= 1'b0;
      else if (roll_i) pp_q <= ~pp_q;
    end
  end

  always_comb begin
    hi_o = 1'b0;
    lo_o = 1'b0;
    if (en_i) begin
      unique case (mode)
        OM_COMPL:    begin hi_o = raw;          lo_o = ~raw;        end
        OM_INDEP:    begin hi_o = raw;          lo_o = raw;         end
        OM_PUSHPULL: begin hi_o = raw && !pp_q; lo_o = raw && pp_q; end
        default:     begin hi_o = 1'b0;         lo_o = 1'b0;        end
      endcase
    end
  end
endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen #(
  parameter int CNT_W  = 13,
  parameter int DUTY_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_mper_i,
  input  logic [CNT_W-1:0]  mper_i,
  input  logic              imm_per_i,
  input  logic              wr_mdc_i,
  input  logic [DUTY_W-1:0] mdc_i,
  input  logic              wr_pdc_i,
  input  logic [DUTY_W-1:0] pdc_i,
  input  logic              wr_ph_i,
  input  logic [CNT_W-1:0]  ph_i,
  input  logic              mdc_sel_i,
  input  logic              itb_i,
  input  logic              imm_duty_i,
  input  logic [1:0]        mode_i,
  output logic              pwm_hi_o,
  output logic              pwm_lo_o,
  output logic [CNT_W-1:0]  ch_cnt_o,
  output logic              mst_roll_o
);
  logic [CNT_W-1:0] mper_act;
  logic             mroll, croll;

  pwm_master_tb #(.CNT_W(CNT_W)) u_master (
    .clk_i, .rst_ni, .en_i,
    .wr_per_i(wr_mper_i), .per_i(mper_i), .imm_per_i,
    .per_act_o(mper_act), .roll_o(mroll)
  );

  pwm_chan_cnt #(.CNT_W(CNT_W)) u_chan (
    .clk_i, .rst_ni, .en_i, .itb_i,
    .mroll_i(mroll), .mper_i(mper_act),
    .wr_ph_i, .ph_i,
    .cnt_o(ch_cnt_o), .roll_o(croll)
  );

  pwm_out_fmt #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_fmt (
    .clk_i, .rst_ni, .en_i,
    .cnt_i(ch_cnt_o), .roll_i(croll),
    .mode_i, .mdc_sel_i, .imm_duty_i,
    .wr_pdc_i, .pdc_i, .wr_mdc_i, .mdc_i,
    .hi_o(pwm_hi_o), .lo_o(pwm_lo_o)
  );

  assign mst_roll_o = mroll;
endmodule

// File: rtl/pwm_phase_gen_chk.sv
module pwm_phase_gen_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [1:0]       mode_i,
  input logic             pwm_hi_o,
  input logic             pwm_lo_o,
  input logic [CNT_W-1:0] ch_cnt_o
);
  // R13
  disabled_cnt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ch_cnt_o == '0));
  // R13
  disabled_pins_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!pwm_hi_o && !pwm_lo_o));
  // R9
  compl_pins_differ_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == 2'b00) |-> (pwm_hi_o != pwm_lo_o));
  // R10
  indep_pins_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == 2'b01) |-> (pwm_hi_o == pwm_lo_o));
  // R11
  pushpull_one_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |-> !(pwm_hi_o && pwm_lo_o));
  // R12
  reserved_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |-> (!pwm_hi_o && !pwm_lo_o));
endmodule

bind pwm_phase_gen pwm_phase_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .en_i, .mode_i, .pwm_hi_o, .pwm_lo_o, .ch_cnt_o
);

// File: tb/pwm_phase_gen_tb.sv
`timescale 1ns/1ps
module pwm_phase_gen_tb;
  localparam int CW = 13;
  localparam int DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, wr_mper = 0, imm_per = 0, wr_mdc = 0, wr_pdc = 0, wr_ph = 0;
  logic mdc_sel = 0, itb = 0, imm_duty = 0;
  logic [CW-1:0] mper = 0, ph = 0;
  logic [DW-1:0] mdc = 0, pdc = 0;
  logic [1:0] mode = 0;
  logic hi, lo, mroll;
  logic [CW-1:0] ccnt;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  pwm_phase_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .wr_mper_i(wr_mper), .mper_i(mper), .imm_per_i(imm_per),
    .wr_mdc_i(wr_mdc), .mdc_i(mdc), .wr_pdc_i(wr_pdc), .pdc_i(pdc),
    .wr_ph_i(wr_ph), .ph_i(ph), .mdc_sel_i(mdc_sel), .itb_i(itb),
    .imm_duty_i(imm_duty), .mode_i(mode),
    .pwm_hi_o(hi), .pwm_lo_o(lo), .ch_cnt_o(ccnt), .mst_roll_o(mroll)
  );

  // reference state from the requirements
  logic [CW-1:0] m_mcnt, m_mper_sh, m_mper_act, m_ph_sh, m_ph_act, m_ccnt;
  logic [DW-1:0] m_pdc, m_mdc, m_duty_act;
  logic          m_pp;

  function automatic logic f_mroll();
    return en && (m_mcnt == m_mper_act);
  endfunction
  function automatic logic f_croll();
    return en && (m_ccnt == (itb ? m_ph_act : m_mper_act));
  endfunction
  function automatic logic f_raw();
    logic [DW-1:0] src, eff;
    src = mdc_sel ? m_mdc : m_pdc;
    eff = imm_duty ? src : m_duty_act;
    return en && ({3'b000, m_ccnt} <= (eff >> 3));
  endfunction
  function automatic logic [1:0] f_pins();
    logic r;
    r = f_raw();
    if (!en) return 2'b00;
    case (mode)
      2'b00: return {r, ~r};
      2'b01: return {r, r};
      2'b10: return {r & ~m_pp, r & m_pp};
      default: return 2'b00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mcnt = 0; m_mper_sh = 0; m_mper_act = 0; m_ph_sh = 0; m_ph_act = 0;
      m_ccnt = 0; m_pdc = 0; m_mdc = 0; m_duty_act = 0; m_pp = 0;
    end else begin
      logic mr, cr;
      logic [CW-1:0] clampv, n_ccnt;
      logic [DW-1:0] src;
      mr = f_mroll(); cr = f_croll();
      src = mdc_sel ? m_mdc : m_pdc;
      clampv = (m_ph_act > m_mper_act) ? m_mper_act : m_ph_act;
      if (!en) n_ccnt = 0;
      else if (!itb && mr) n_ccnt = clampv;
      else if (cr) n_ccnt = 0;
      else n_ccnt = m_ccnt + 1'b1;
      if (!en || cr) begin m_ph_act = m_ph_sh; m_duty_act = src; end
      if (!en) m_pp = 0; else if (cr) m_pp = ~m_pp;
      if (wr_mper && imm_per) m_mper_act = mper;
      else if (!en || mr) m_mper_act = m_mper_sh;
      m_mcnt = (!en || mr) ? 0 : m_mcnt + 1'b1;
      m_ccnt = n_ccnt;
      if (wr_mper) m_mper_sh = mper;
      if (wr_ph) m_ph_sh = ph;
      if (wr_pdc) m_pdc = pdc;
      if (wr_mdc) m_mdc = mdc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mode_tag();
    if (!en) return "R13";
    case (mode)
      2'b00: return "R9";
      2'b01: return "R10";
      2'b10: return "R11";
      default: return "R12";
    endcase
  endfunction

  // compare all outputs, then drive the next stimulus
  task automatic check_cycle();
    logic [1:0] p;
    p = f_pins();
    chk($sformatf("R6 R7 R8 %s hi", mode_tag()), hi, p[1]);
    chk($sformatf("R6 R7 R8 %s lo", mode_tag()), lo, p[0]);
    chk(itb ? "R5 R4 ch_cnt" : "R3 R2 R4 ch_cnt", ccnt, m_ccnt);
    chk("R1 mst_roll", mroll, f_mroll());
  endtask

  task automatic clear_strobes();
    wr_mper = 0; wr_mdc = 0; wr_pdc = 0; wr_ph = 0;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 13;
    void'($urandom(seed));
    #5;
    // R13: reset state
    chk("R13 reset hi", hi, 0);
    chk("R13 reset lo", lo, 0);
    chk("R13 reset cnt", ccnt, 0);
    rst_n = 1;
    @(negedge clk);

    // directed R3 clamp: phase 9 > period 5 reloads 5
    wr_mper = 1; mper = 5; wr_ph = 1; ph = 9; wr_pdc = 1; pdc = 16'h0010;
    @(negedge clk); check_cycle(); clear_strobes();
    @(negedge clk); check_cycle();
    en = 1;
    begin
      int guard = 0;
      do begin @(negedge clk); check_cycle(); guard++; end
      while (!mroll && guard < 50);
    end
    @(negedge clk);
    chk("R3 clamped phase reload", ccnt, 5);
    check_cycle();

    // directed R11: push-pull starts on high pin after enable
    en = 0; mode = 2'b10;
    wr_pdc = 1; pdc = 16'hFFF0;
    @(negedge clk); check_cycle(); clear_strobes();
    en = 1;
    @(negedge clk);
    chk("R11 first pulse on high pin", hi, 1);
    chk("R11 low pin idle", lo, 0);
    check_cycle();

    // directed R6: low duty bits ignored, counter 0 vs duty 7 -> 0
    en = 0; mode = 2'b01; wr_pdc = 1; pdc = 16'h0007;
    @(negedge clk); check_cycle(); clear_strobes();
    @(negedge clk); check_cycle();
    en = 1;
    @(negedge clk);
    chk("R6 duty 0 still active at count 0", hi, (ccnt == 0) ? 1 : 0);
    check_cycle();

    // random episodes
    for (int ep = 0; ep < 60; ep++) begin
      en = 0;
      wr_mper = 1; mper = CW'(3 + $urandom_range(0, 17));
      wr_ph = 1;   ph = CW'($urandom_range(0, 25));
      @(negedge clk); check_cycle(); clear_strobes();
      itb = $urandom_range(0, 1);
      if (itb) begin wr_ph = 1; ph = CW'(2 + $urandom_range(0, 18)); end
      mode = 2'($urandom_range(0, 3));
      mdc_sel = $urandom_range(0, 1);
      imm_duty = $urandom_range(0, 1);
      imm_per = $urandom_range(0, 1);
      wr_pdc = 1; pdc = DW'($urandom_range(0, 24) * 8 + $urandom_range(0, 7));
      wr_mdc = 1; mdc = DW'($urandom_range(0, 24) * 8 + $urandom_range(0, 7));
      @(negedge clk); check_cycle(); clear_strobes();
      @(negedge clk); check_cycle();
      en = 1;
      for (int c = 0; c < 80; c++) begin
        @(negedge clk); check_cycle(); clear_strobes();
        if ($urandom_range(0, 7) == 0) begin
          wr_pdc = 1; pdc = DW'($urandom_range(0, 24) * 8 + $urandom_range(0, 7));
        end
        if ($urandom_range(0, 7) == 0) begin
          wr_mdc = 1; mdc = DW'($urandom_range(0, 24) * 8 + $urandom_range(0, 7));
        end
        if ($urandom_range(0, 9) == 0) begin
          wr_ph = 1;
          ph = itb ? CW'(2 + $urandom_range(0, 18)) : CW'($urandom_range(0, 25));
        end
        if ($urandom_range(0, 15) == 0) begin
          wr_mper = 1; mper = CW'(3 + $urandom_range(0, 17));
        end
        if ($urandom_range(0, 19) == 0) mdc_sel = ~mdc_sel;
      end
    end
    clear_strobes();
    en = 0;
    @(negedge clk); check_cycle();
    @(negedge clk); check_cycle();
    chk("R13 counter held after disable", ccnt, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule